// File: doc/BRIEF.md
# Fused-Operation Integer Unit

This unit executes the compound opcodes that a macro-op fusion stage emits after it merges two adjacent integer instructions into one. A single opcode covers what a pair of instructions would do one after the other: a shift followed by an add, a zero-extension followed by a shift, a word add followed by a narrowing step, a logic operation followed by a narrowing step, or a byte mask followed by an OR. Some of these opcodes have no single-instruction equivalent. Examples are a logical right shift followed by an add, and a word add whose sum is narrowed.

Each cycle the issue side presents a 5-bit opcode, two 64-bit operands and a valid flag. The result appears one cycle later from a registered stage, together with a valid flag. If the opcode is unknown, the result is zero and an illegal flag is raised alongside it. The unit has no stall path. It accepts one operation per cycle.

Top module: `fused_alu`

## Requirements
- R1: Opcodes 3, 4, 5 and 6 return (src1 << k) + src2 over 64 bits, for k = 1, 2, 3 and 4 respectively.
- R2: Opcodes 7, 8, 9 and 10 return (src1 >> k) + src2 over 64 bits. The right shift is logical, with k = 29, 30, 31 and 32 respectively.
- R3: Opcode 0 returns the low 32 bits of src1 with the upper 32 bits zero. Opcodes 11, 12 and 13 return that zero-extended word shifted left by 1, 2 and 3 respectively.
- R4: Opcode 1 returns src1[15:0] zero-extended to 64 bits. Opcode 2 returns src1[15:0] sign-extended from bit 15.
- R5: Opcode 14 returns src1[15:8] in bits 7:0, with all other bits zero.
- R6: Opcode 15 returns src2 + (src1 & 1) over 64 bits. Opcode 16 forms the same sum over 32 bits and sign-extends bit 31 of it.
- R7: Let w be the 32-bit sum src1[31:0] + src2[31:0]. Opcode 17 returns w[7:0] zero-extended. Opcode 18 returns w[0] zero-extended. Opcode 19 returns w[15:0] zero-extended. Opcode 20 returns w[15:0] sign-extended.
- R8: Opcodes 21, 22 and 23 return bit 0 of src1 AND, OR and XOR src2 respectively, zero-extended. Opcodes 24, 25 and 26 return the low 16 bits of the same three results, zero-extended.
- R9: Opcode 27 returns (src1 with bits 7:0 cleared) OR src2.
- R10: Opcodes 28 to 31 return a zero result and raise illegal_o. Opcodes 0 to 27 never raise illegal_o.
- R11: out_valid_o is in_valid_i delayed by exactly one clock. result_o and illegal_o belong to the operation accepted on that same edge.
- R12: When in_valid_i is low, result_o keeps its previous value on the next cycle and illegal_o is low.
- R13: While rst_ni is low, out_valid_o, illegal_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Fused opcode |
| src1_i | input | 64 | First operand |
| src2_i | input | 64 | Second operand |
| out_valid_o | output | 1 | Registered result is valid |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Registered opcode was unknown |

## Verification
The opcodes are easy to reach. The hard part is operands that sit exactly at the word boundary. Only there does a word-narrowed sum differ from the 64-bit sum, does the logical right shift by 29 to 32 bring upper bits down, and does the zero-extend-then-shift forms drop bit 32 and above. To cover these cases, the stimulus crosses every opcode value, including the four illegal ones, with a fixed set of corner operands: all ones, 0x8000_0000, 0xFFFF_FFFF, 0x7FFF_FFFF and words that carry out of bit 31. Idle cycles with garbage on the inputs are inserted between operations to test result holding, and a random phase follows the cross. Every result is compared with a model written as the original two-instruction sequence.

// File: rtl/fused_alu_pkg.sv
package fused_alu_pkg;
  localparam int unsigned OP_W   = 5;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [OP_W-1:0] {
    FOP_ZEXT_W     = 5'd0,
    FOP_ZEXT_H     = 5'd1,
    FOP_SEXT_H     = 5'd2,
    FOP_SH1ADD     = 5'd3,
    FOP_SH2ADD     = 5'd4,
    FOP_SH3ADD     = 5'd5,
    FOP_SH4ADD     = 5'd6,
    FOP_SR29ADD    = 5'd7,
    FOP_SR30ADD    = 5'd8,
    FOP_SR31ADD    = 5'd9,
    FOP_SR32ADD    = 5'd10,
    FOP_SZEWL1     = 5'd11,
    FOP_SZEWL2     = 5'd12,
    FOP_SZEWL3     = 5'd13,
    FOP_BYTE1      = 5'd14,
    FOP_ODDADD     = 5'd15,
    FOP_ODDADDW    = 5'd16,
    FOP_ADDW_BYTE  = 5'd17,
    FOP_ADDW_BIT   = 5'd18,
    FOP_ADDW_ZEXTH = 5'd19,
    FOP_ADDW_SEXTH = 5'd20,
    FOP_AND_LSB    = 5'd21,
    FOP_OR_LSB     = 5'd22,
    FOP_XOR_LSB    = 5'd23,
    FOP_AND_ZEXTH  = 5'd24,
    FOP_OR_ZEXTH   = 5'd25,
    FOP_XOR_ZEXTH  = 5'd26,
    FOP_ORH48      = 5'd27
  } fop_e;

  localparam logic [OP_W-1:0] FOP_LAST = FOP_ORH48;

  // narrowing step applied after source selection
  typedef enum logic [2:0] {
    NR_NONE,
    NR_BYTE,
    NR_BIT,
    NR_ZH,
    NR_SH,
    NR_SW,
    NR_MOR
  } narrow_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR
  } logic_e;

  // opcodes served by the shared 64-bit adder path
  function automatic logic in_add_path(logic [OP_W-1:0] op);
    return (op == FOP_ZEXT_W) || ((op >= FOP_SH1ADD) && (op <= FOP_ODDADD));
  endfunction
endpackage

// File: rtl/fused_add_unit.sv
module fused_add_unit
  import fused_alu_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NSHIFT  = 4,
  parameter int unsigned SR_BASE = 29
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  output logic [XLEN-1:0] sum_o
);
  localparam int unsigned IDX_W = (NSHIFT > 1) ? $clog2(NSHIFT) : 1;

  logic [XLEN-1:0] zw;
  logic [XLEN-1:0] shl [NSHIFT];
  logic [XLEN-1:0] shr [NSHIFT];
  logic [XLEN-1:0] zws [NSHIFT];

  assign zw = {{(XLEN-WORD_W){1'b0}}, src1_i[WORD_W-1:0]};

  for (genvar g = 0; g < NSHIFT; g++) begin : g_shift
    assign shl[g] = src1_i << (g + 1);
    assign shr[g] = src1_i >> (SR_BASE + g);
    assign zws[g] = zw << g;
  end

  logic [XLEN-1:0] opa;
  logic            use_b;
  logic [IDX_W-1:0] idx_sl, idx_sr, idx_zw;

  assign idx_sl = IDX_W'(op_i - FOP_SH1ADD);
  assign idx_sr = IDX_W'(op_i - FOP_SR29ADD);
  assign idx_zw = IDX_W'(op_i - FOP_SZEWL1 + 1);

  // operand steering into one adder; non-add forms add zero
  always_comb begin
    opa   = '0;
    use_b = 1'b0;
    case (op_i) inside
      FOP_ZEXT_W: opa = zws[0];
      [FOP_SH1ADD:FOP_SH4ADD]: begin
        opa   = shl[idx_sl];
        use_b = 1'b1;
      end
      [FOP_SR29ADD:FOP_SR32ADD]: begin
        opa   = shr[idx_sr];
        use_b = 1'b1;
      end
      [FOP_SZEWL1:FOP_SZEWL3]: opa = zws[idx_zw];
      FOP_BYTE1: opa = {{(XLEN-BYTE_W){1'b0}}, src1_i[2*BYTE_W-1:BYTE_W]};
      FOP_ODDADD: begin
        opa   = {{(XLEN-1){1'b0}}, src1_i[0]};
        use_b = 1'b1;
      end
      default: ;
    endcase
  end

  assign sum_o = opa + (use_b ? src2_i : '0);
endmodule

// File: rtl/fused_narrow_unit.sv
module fused_narrow_unit
  import fused_alu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  output logic [XLEN-1:0] res_o
);
  localparam logic [XLEN-1:0] LOW_BYTE = XLEN'({BYTE_W{1'b1}});

  logic [WORD_W-1:0] wa, wsum;
  logic [XLEN-1:0]   lres, nsrc;
  narrow_e           mode;
  logic_e            lkind;

  assign wa   = (op_i == FOP_ODDADDW) ? {{(WORD_W-1){1'b0}}, src1_i[0]} : src1_i[WORD_W-1:0];
  assign wsum = wa + src2_i[WORD_W-1:0];

  always_comb begin
    case (op_i)
      FOP_OR_LSB, FOP_OR_ZEXTH:   lkind = LG_OR;
      FOP_XOR_LSB, FOP_XOR_ZEXTH: lkind = LG_XOR;
      default:                    lkind = LG_AND;
    endcase
    case (lkind)
      LG_OR:   lres = src1_i | src2_i;
      LG_XOR:  lres = src1_i ^ src2_i;
      default: lres = src1_i & src2_i;
    endcase
  end

  // source select and narrowing mode per opcode
  always_comb begin
    nsrc = src1_i;
    mode = NR_NONE;
    case (op_i) inside
      FOP_ZEXT_H:     mode = NR_ZH;
      FOP_SEXT_H:     mode = NR_SH;
      FOP_ODDADDW:    begin nsrc = XLEN'(wsum); mode = NR_SW;   end
      FOP_ADDW_BYTE:  begin nsrc = XLEN'(wsum); mode = NR_BYTE; end
      FOP_ADDW_BIT:   begin nsrc = XLEN'(wsum); mode = NR_BIT;  end
      FOP_ADDW_ZEXTH: begin nsrc = XLEN'(wsum); mode = NR_ZH;   end
      FOP_ADDW_SEXTH: begin nsrc = XLEN'(wsum); mode = NR_SH;   end
      [FOP_AND_LSB:FOP_XOR_LSB]:     begin nsrc = lres; mode = NR_BIT; end
      [FOP_AND_ZEXTH:FOP_XOR_ZEXTH]: begin nsrc = lres; mode = NR_ZH;  end
      FOP_ORH48:      mode = NR_MOR;
      default: ;
    endcase
  end

  always_comb begin
    case (mode)
      NR_BYTE: res_o = {{(XLEN-BYTE_W){1'b0}}, nsrc[BYTE_W-1:0]};
      NR_BIT:  res_o = {{(XLEN-1){1'b0}}, nsrc[0]};
      NR_ZH:   res_o = {{(XLEN-HALF_W){1'b0}}, nsrc[HALF_W-1:0]};
      NR_SH:   res_o = {{(XLEN-HALF_W){nsrc[HALF_W-1]}}, nsrc[HALF_W-1:0]};
      NR_SW:   res_o = {{(XLEN-WORD_W){nsrc[WORD_W-1]}}, nsrc[WORD_W-1:0]};
      NR_MOR:  res_o = (src1_i & ~LOW_BYTE) | src2_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/fused_out_reg.sv
module fused_out_reg #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            illegal_i,
  input  logic [XLEN-1:0] res_i,
  output logic            valid_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      res_o     <= '0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i & illegal_i;
      if (valid_i) res_o <= res_i;
    end
  end
endmodule

// File: rtl/fused_alu.sv
module fused_alu
  import fused_alu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [4:0]      op_i,
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  output logic            out_valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  logic [XLEN-1:0] add_res, nar_res, comb_res;
  logic            bad_op;

  fused_add_unit #(.XLEN(XLEN)) i_add (
    .op_i   (op_i),
    .src1_i (src1_i),
    .src2_i (src2_i),
    .sum_o  (add_res)
  );

  fused_narrow_unit #(.XLEN(XLEN)) i_narrow (
    .op_i   (op_i),
    .src1_i (src1_i),
    .src2_i (src2_i),
    .res_o  (nar_res)
  );

  assign bad_op   = op_i > FOP_LAST;
  assign comb_res = bad_op ? '0 : (in_add_path(op_i) ? add_res : nar_res);

  fused_out_reg #(.XLEN(XLEN)) i_oreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (in_valid_i),
    .illegal_i (bad_op),
    .res_i     (comb_res),
    .valid_o   (out_valid_o),
    .illegal_o (illegal_o),
    .res_o     (result_o)
  );
endmodule

// File: rtl/fused_alu_chk.sv
module fused_alu_chk
  import fused_alu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic [4:0]      op_i,
  input logic [XLEN-1:0] src1_i,
  input logic [XLEN-1:0] src2_i,
  input logic            out_valid_o,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o
);
  p_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));
  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !illegal_o);
  p_illegal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i > FOP_LAST) |=> (illegal_o && result_o == '0));
  p_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i <= FOP_LAST) |=> !illegal_o);
  p_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == FOP_BYTE1) |=> (result_o[XLEN-1:BYTE_W] == '0));
  p_lsb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i >= FOP_AND_LSB && op_i <= FOP_XOR_LSB) |=> (result_o[XLEN-1:1] == '0));
  p_mor_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == FOP_ORH48) |=> (result_o[BYTE_W-1:0] == $past(src2_i[BYTE_W-1:0])));
endmodule

bind fused_alu fused_alu_chk #(.XLEN(XLEN)) i_fused_alu_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .op_i        (op_i),
  .src1_i      (src1_i),
  .src2_i      (src2_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o),
  .illegal_o   (illegal_o)
);

// File: tb/test_fused_alu.sv
`timescale 1ns/1ps
module test_fused_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [63:0] src1_i = '0;
  logic [63:0] src2_i = '0;
  logic        out_valid_o;
  logic [63:0] result_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        exp_valid = 1'b0;
  logic [63:0] exp_res = '0;
  logic        exp_ill = 1'b0;
  logic        last_in_valid = 1'b0;
  string       last_tag = "R13";
  logic [63:0] corner [8];

  always #2.5 clk_i = ~clk_i;

  fused_alu i_fused_alu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .op_i        (op_i),
    .src1_i      (src1_i),
    .src2_i      (src2_i),
    .out_valid_o (out_valid_o),
    .result_o    (result_o),
    .illegal_o   (illegal_o)
  );

  function automatic logic [63:0] sx32(logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [63:0] sx16(logic [15:0] h);
    return {{48{h[15]}}, h};
  endfunction

  // model as the two-instruction sequence
  function automatic logic [63:0] ref_op(int op, logic [63:0] a, logic [63:0] b);
    logic [63:0] t;
    case (op)
      0:  ref_op = a & 64'h0000_0000_FFFF_FFFF;
      1:  ref_op = a & 64'hFFFF;
      2:  ref_op = sx16(a[15:0]);
      3, 4, 5, 6: begin t = a << (op - 2); ref_op = t + b; end
      7, 8, 9, 10: begin t = a >> (op + 22); ref_op = t + b; end
      11, 12, 13: begin t = a & 64'h0000_0000_FFFF_FFFF; ref_op = t << (op - 10); end
      14: begin t = a >> 8; ref_op = t & 64'd255; end
      15: begin t = a & 64'd1; ref_op = t + b; end
      16: begin t = a & 64'd1; t = t + b; ref_op = sx32(t[31:0]); end
      17: begin t = sx32(a[31:0] + b[31:0]); ref_op = t & 64'd255; end
      18: begin t = sx32(a[31:0] + b[31:0]); ref_op = t & 64'd1; end
      19: begin t = sx32(a[31:0] + b[31:0]); ref_op = t & 64'hFFFF; end
      20: begin t = sx32(a[31:0] + b[31:0]); ref_op = sx16(t[15:0]); end
      21: begin t = a & b; ref_op = t & 64'd1; end
      22: begin t = a | b; ref_op = t & 64'd1; end
      23: begin t = a ^ b; ref_op = t & 64'd1; end
      24: begin t = a & b; ref_op = t & 64'hFFFF; end
      25: begin t = a | b; ref_op = t & 64'hFFFF; end
      26: begin t = a ^ b; ref_op = t & 64'hFFFF; end
      27: begin t = a & ~64'd255; ref_op = t | b; end
      default: ref_op = '0;
    endcase
  endfunction

  function automatic string tag_of(int op);
    if (op == 0 || (op >= 11 && op <= 13)) return "R3";
    if (op >= 3 && op <= 6)   return "R1";
    if (op >= 7 && op <= 10)  return "R2";
    if (op == 1 || op == 2)   return "R4";
    if (op == 14)             return "R5";
    if (op == 15 || op == 16) return "R6";
    if (op >= 17 && op <= 20) return "R7";
    if (op >= 21 && op <= 26) return "R8";
    if (op == 27)             return "R9";
    return "R10";
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare outputs of previous step, then drive next operation
  task automatic step(logic v, int op, logic [63:0] a, logic [63:0] b);
    @(negedge clk_i);
    chk(out_valid_o == exp_valid, "R11", "out_valid", 64'(out_valid_o), 64'(exp_valid));
    chk(result_o == exp_res, last_in_valid ? last_tag : "R12", "result", result_o, exp_res);
    chk(illegal_o == exp_ill, last_in_valid ? "R10" : "R12", "illegal", 64'(illegal_o), 64'(exp_ill));
    in_valid_i = v;
    op_i       = 5'(op);
    src1_i     = a;
    src2_i     = b;
    exp_valid  = v;
    last_in_valid = v;
    if (v) begin
      exp_res  = ref_op(op, a, b);
      exp_ill  = (op > 27);
      last_tag = tag_of(op);
    end else begin
      exp_ill = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    corner[0] = 64'h0;
    corner[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    corner[2] = 64'h0000_0000_8000_0000;
    corner[3] = 64'h0000_0000_FFFF_FFFF;
    corner[4] = 64'h0000_0000_7FFF_FFFF;
    corner[5] = 64'h0000_0001_FFFF_FF81;
    corner[6] = 64'h1234_5678_9ABC_DEF0;
    corner[7] = 64'hFFFF_FFFF_0000_80FF;

    // R13 reset state with inputs active
    in_valid_i = 1'b1;
    op_i = 5'd3;
    src1_i = 64'hFFFF;
    src2_i = 64'h1;
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R13", "out_valid", 64'(out_valid_o), 64'd0);
    chk(result_o == '0, "R13", "result", result_o, 64'd0);
    chk(illegal_o == 1'b0, "R13", "illegal", 64'(illegal_o), 64'd0);
    in_valid_i = 1'b0;
    rst_ni = 1'b1;

    n = 0;
    for (int op = 0; op < 32; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          step(1'b1, op, corner[i], corner[j]);
          n++;
          if (n % 5 == 0)
            step(1'b0, int'($urandom_range(31)), {$urandom, $urandom}, {$urandom, $urandom});
        end
      end
    end

    for (int k = 0; k < 1500; k++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(3) == 0) a = corner[$urandom_range(7)];
      step(($urandom_range(4) != 0), int'($urandom_range(31)), a, b);
    end
    step(1'b0, 0, '0, '0);
    step(1'b0, 0, '0, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule